// File: doc/BRIEF.md
# Byte Serial Port with Master Demotion

This block moves one byte at a time over a four-wire synchronous serial link. It can be the side that drives the serial clock (master) or the side that follows a clock from elsewhere (slave). A control write loads the master-select, clock polarity, clock phase, a two-bit rate code and a double-speed bit. A write to the transmit strobe loads the outgoing byte. In master mode that write also starts the transfer. Every transfer ends by raising one flag, which stays high until a dedicated clear input is pulsed.

As master, the block divides the system clock by a rate picked from a three-bit code to make the serial clock. As slave, it samples the external clock, data and select through synchronizers, and shifts only while the select input is low. If the select input goes low while the block is master, another device is taking the bus. The block then drops to slave, raises the flag, and stays a slave until a new control write sets master again.

Top module: `spi_port`

## Requirements
- R1: After reset the block is a slave with every control bit zero. The flag is low, the received byte is 0, and none of the serial clock, MOSI or MISO outputs is enabled.
- R2: While the master bit is 1, the block enables its serial clock and MOSI outputs. While it is 0, it enables neither, and a transmit write produces no serial clock.
- R3: In master mode the serial clock rests at the polarity bit's level (0 = low, 1 = high) whenever no transfer runs, and it returns to that level after the sixteenth edge.
- R4: Bytes travel MSB first. The leading edge is rising for polarity 0 and falling for polarity 1. With phase 0, data is sampled on leading edges and changed on trailing edges, and the first bit is already on the line before the first edge. With phase 1, data is changed on leading edges and sampled on trailing edges.
- R5: Each master half-period is a fixed number of system clocks. With double speed 0, the rate code (0,1,2,3) gives that number as (2,8,32,64), which is a clock division of 4, 16, 64 and 128. With double speed 1, the rate code (0,1,2,3) gives (1,4,16,32), a division of 2, 8, 32 and 64.
- R6: In master mode, a transmit write while idle starts a transfer of exactly 16 serial clock edges. The flag rises by the end of the transfer, at the eighth sampling edge, and the received byte appears on the received-data output.
- R7: In slave mode the block shifts on the external serial clock, drives MISO, and sets the flag after eight sampling edges. The rate code and double-speed bit have no effect on it.
- R8: In slave mode, a high select input enables no MISO output and returns the bit count to zero. A byte cut short by a high select does not set the flag and does not disturb the next byte.
- R9: In master mode, a low select input clears the master bit, raises the flag and releases the serial clock. The block stays a slave after the select input returns high.
- R10: A pulse on the clear input lowers the flag, unless the flag is being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_i | input | 1 | Loads all control bits below |
| cfg_master_i | input | 1 | 1 = master, 0 = slave |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_cpha_i | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_rate_i | input | 2 | Master clock rate code |
| cfg_dbl_i | input | 1 | Halves the master division |
| tx_wr_i | input | 1 | Transmit-byte write strobe |
| tx_data_i | input | DATA_W (8) | Byte to send |
| rx_data_o | output | DATA_W (8) | Last byte received |
| flag_o | output | 1 | Transfer done or mode fault |
| flag_clr_i | input | 1 | Clears the flag |
| master_o | output | 1 | Current master bit |
| ss_n_i | input | 1 | Active-low select input |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Data in from the bus (slave) |
| mosi_o | output | 1 | Data out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Data in from the bus (master) |
| miso_o | output | 1 | Data out (slave) |
| miso_oe_o | output | 1 | MISO output enable |

## Verification
The following properties are checked on every cycle:
- a fault must clear the master bit and set the flag on the next cycle;
- a clear must drop the flag;
- the serial clock must hold between divider ticks;
- a master transfer must end only after sixteen edges;
- a restart or a completed byte must zero the bit count;
- leaving master mode must stop the clock generator.

The bench scenarios cover the rest:
- the measured half-period for all eight rate settings;
- MSB-first exchange of data under every polarity and phase pair;
- slave indifference to the rate bits;
- recovery from a byte cut short by the select line.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef logic [1:0] rate_t;

  // log2 of the master half-period in system clocks
  function automatic logic [2:0] half_exp(input rate_t rate, input logic dbl);
    logic [2:0] e;
    case (rate)
      2'd0:    e = 3'd1;
      2'd1:    e = 3'd3;
      2'd2:    e = 3'd5;
      default: e = 3'd6;
    endcase
    return e - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       cpol_i,
  input  logic [2:0] half_exp_i,
  output logic       sck_o,
  output logic       busy_o,
  output logic       edge_o,
  output logic       lead_o
);
  localparam int EC_W = $clog2(2 * DATA_W);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(2 * DATA_W - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EC_W-1:0]  ec_q, ec_d;
  logic             sck_q, sck_d;
  logic [CNT_W:0]   span;
  logic             tick;

  always_comb begin
    span = ({{CNT_W{1'b0}}, 1'b1} << half_exp_i) - 1'b1;
    tick = busy_q && ({1'b0, cnt_q} == span);
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ec_d   = ec_q;
    sck_d  = sck_q;
    if (abort_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      ec_d   = '0;
      sck_d  = cpol_i;
    end else if (!busy_q) begin
      cnt_d = '0;
      ec_d  = '0;
      sck_d = cpol_i;
      if (start_i) busy_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
      ec_d  = ec_q + 1'b1;
      if (ec_q == EC_LAST) busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ec_q   <= '0;
      sck_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ec_q   <= ec_d;
      sck_q  <= sck_d;
    end
  end

  assign sck_o  = busy_q ? sck_q : cpol_i;
  assign busy_o = busy_q;
  assign edge_o = tick && !abort_i;
  assign lead_o = ~ec_q[0];

  // R6: a normal end of transfer happens only after the last edge
  a_r6_full_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(abort_i)) |-> ($past(ec_q) == EC_LAST));

  // R5: the clock level holds between divider ticks
  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ({1'b0, cnt_q} != span) && !abort_i) |=> $stable(sck_q));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              restart_i,
  input  logic              sample_i,
  input  logic              setup_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic              pend_q, pend_d, samp_q, samp_d;
  logic              last_sample;

  assign last_sample = sample_i && !restart_i && (bit_q == BC_LAST);

  always_comb begin
    sh_d   = sh_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    pend_d = pend_q;
    samp_d = samp_q;
    if (restart_i) begin
      bit_d  = '0;
      pend_d = 1'b0;
    end else if (sample_i) begin
      if (bit_q == BC_LAST) begin
        rx_d   = {sh_q[DATA_W-2:0], din_i};
        bit_d  = '0;
        pend_d = 1'b0;
      end else begin
        samp_d = din_i;
        pend_d = 1'b1;
        bit_d  = bit_q + 1'b1;
      end
    end else if (setup_i && pend_q) begin
      sh_d   = {sh_q[DATA_W-2:0], samp_q};
      pend_d = 1'b0;
    end
    if (load_i) sh_d = load_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      pend_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      pend_q <= pend_d;
      samp_q <= samp_d;
    end
  end

  assign dout_o = sh_q[DATA_W-1];
  assign done_o = last_sample;
  assign rx_o   = rx_q;

  // R6: a completed byte leaves the counter ready for the next one
  a_r6_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (bit_q == '0) && !pend_q);

  // R8: a restart clears the partial byte state
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (bit_q == '0) && !pend_q);

  // R4: a setup edge moves the held sample into the register LSB
  a_r4_setup_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_i && pend_q && !restart_i && !sample_i && !load_i) |=> (sh_q[0] == $past(samp_q)));

endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              cfg_master_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic [1:0]        cfg_rate_i,
  input  logic              cfg_dbl_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              flag_o,
  input  logic              flag_clr_i,
  output logic              master_o,
  input  logic              ss_n_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  import spi_pkg::*;

  localparam int SYNC_N = 3;

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // input synchronizers for bus pins
  logic [SYNC_N-1:0] ss_sy, sck_sy, mo_sy;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ss_sy  <= '1;
      sck_sy <= '0;
      mo_sy  <= '0;
    end else begin
      ss_sy  <= {ss_sy[SYNC_N-2:0], ss_n_i};
      sck_sy <= {sck_sy[SYNC_N-2:0], sck_i};
      mo_sy  <= {mo_sy[SYNC_N-2:0], mosi_i};
    end
  end

  logic ss_s, sck_s, sck_p, mosi_s;
  assign ss_s   = ss_sy[1];
  assign sck_s  = sck_sy[1];
  assign sck_p  = sck_sy[2];
  assign mosi_s = mo_sy[1];

  // control bits and flag
  logic  mstr_q, mstr_d, cpol_q, cpha_q, dbl_q, flag_q, flag_d;
  rate_t rate_q;
  logic  fault, done;

  assign fault = mstr_q && !ss_s;

  always_comb begin
    mstr_d = mstr_q;
    if (fault)         mstr_d = 1'b0;
    else if (cfg_wr_i) mstr_d = cfg_master_i;
    flag_d = flag_q;
    if (done || fault)   flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mstr_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      rate_q <= '0;
      dbl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      mstr_q <= mstr_d;
      flag_q <= flag_d;
      if (cfg_wr_i) begin
        cpol_q <= cfg_cpol_i;
        cpha_q <= cfg_cpha_i;
        rate_q <= cfg_rate_i;
        dbl_q  <= cfg_dbl_i;
      end
    end
  end

  // master clock generation
  logic m_busy, m_edge, m_lead, m_sck, m_start, m_abort;
  assign m_abort = fault || !mstr_q;
  assign m_start = mstr_q && !fault && tx_wr_i && !m_busy;

  spi_sck_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) sck_gen_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .start_i    (m_start),
    .abort_i    (m_abort),
    .cpol_i     (cpol_q),
    .half_exp_i (half_exp(rate_q, dbl_q)),
    .sck_o      (m_sck),
    .busy_o     (m_busy),
    .edge_o     (m_edge),
    .lead_o     (m_lead)
  );

  // edge selection for both roles
  logic s_act, s_rise, s_fall, s_lead, s_trail;
  logic sample, setup, restart, load, din, dout;
  always_comb begin
    s_act   = !mstr_q && !ss_s;
    s_rise  = sck_s && !sck_p;
    s_fall  = !sck_s && sck_p;
    s_lead  = cpol_q ? s_fall : s_rise;
    s_trail = cpol_q ? s_rise : s_fall;
    if (mstr_q) begin
      sample = m_edge && (m_lead != cpha_q);
      setup  = m_edge && (m_lead == cpha_q);
      din    = miso_i;
    end else begin
      sample = s_act && (cpha_q ? s_trail : s_lead);
      setup  = s_act && (cpha_q ? s_lead : s_trail);
      din    = mosi_s;
    end
    restart = fault || (!mstr_q && ss_s);
    load    = m_start || (!mstr_q && tx_wr_i);
  end

  spi_shift_core #(.DATA_W(DATA_W)) shift_i (
    .clk         (clk),
    .rst_n       (rst_q),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .restart_i   (restart),
    .sample_i    (sample),
    .setup_i     (setup),
    .din_i       (din),
    .dout_o      (dout),
    .done_o      (done),
    .rx_o        (rx_data_o)
  );

  assign flag_o    = flag_q;
  assign master_o  = mstr_q;
  assign sck_o     = m_sck;
  assign sck_oe_o  = mstr_q;
  assign mosi_o    = dout;
  assign mosi_oe_o = mstr_q;
  assign miso_o    = dout;
  assign miso_oe_o = s_act;

  // R9: a low select in master mode demotes and flags
  a_r9_mode_fault: assert property (@(posedge clk) disable iff (!rst_q)
    fault |=> (!mstr_q && flag_q));

  // R10: a clear with no competing set lowers the flag
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_clr_i && !done && !fault) |=> !flag_q);

  // R2: the clock generator stays stopped outside master mode
  a_r2_slave_no_clock: assert property (@(posedge clk) disable iff (!rst_q)
    !mstr_q |=> !m_busy);

endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr_i, cfg_master_i, cfg_cpol_i, cfg_cpha_i, cfg_dbl_i;
  logic [1:0] cfg_rate_i;
  logic       tx_wr_i, flag_clr_i;
  logic [7:0] tx_data_i, rx_data_o;
  logic       flag_o, master_o, ss_n_i, sck_i, sck_o, sck_oe_o;
  logic       mosi_i, mosi_o, mosi_oe_o, miso_i, miso_o, miso_oe_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr_i), .cfg_master_i(cfg_master_i), .cfg_cpol_i(cfg_cpol_i),
    .cfg_cpha_i(cfg_cpha_i), .cfg_rate_i(cfg_rate_i), .cfg_dbl_i(cfg_dbl_i),
    .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .rx_data_o(rx_data_o),
    .flag_o(flag_o), .flag_clr_i(flag_clr_i), .master_o(master_o),
    .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic m, input logic pol, input logic pha,
                           input logic [1:0] rt, input logic dbl);
    @(negedge clk);
    cfg_master_i = m; cfg_cpol_i = pol; cfg_cpha_i = pha; cfg_rate_i = rt; cfg_dbl_i = dbl;
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic clear_flag(input string req);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk(req, flag_o, 1'b0);
  endtask

  task automatic run_master(input logic pol, input logic pha, input logic [1:0] rt,
                            input logic dbl, input logic [7:0] tx, input logic [7:0] sv);
    int half, cyc;
    logic [7:0] sb, cap;
    logic pend, prev, per_ok;
    half = 1 << ((rt == 2'd0 ? 1 : rt == 2'd1 ? 3 : rt == 2'd2 ? 5 : 6) - int'(dbl));
    write_cfg(1'b1, pol, pha, rt, dbl);
    chk("R3 idle level", sck_o, pol);
    chk("R2 master enables", {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b110);
    sb = sv; miso_i = sb[7]; pend = 1'b0; cap = '0; per_ok = 1'b1;
    tx_data_i = tx; tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
    prev = sck_o;
    for (int k = 0; k < 16; k++) begin
      logic lead, is_samp;
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
      end while (sck_o == prev && cyc < 300);
      if (cyc != half) per_ok = 1'b0;
      prev = sck_o;
      lead = (k % 2) == 0;
      is_samp = pha ? !lead : lead;
      if (is_samp) begin
        cap = {cap[6:0], mosi_o};
        pend = 1'b1;
      end else if (pend) begin
        sb = {sb[6:0], 1'b0};
        miso_i = sb[7];
        pend = 1'b0;
      end
    end
    chk("R5 half period", per_ok, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 flag after byte", flag_o, 1'b1);
    chk("R6 received byte", rx_data_o, sv);
    chk("R4 MSB-first mosi", cap, tx);
    chk("R3 return to idle", sck_o, pol);
    clear_flag("R10 clear");
  endtask

  task automatic run_slave(input logic pol, input logic pha, input logic [1:0] rt,
                           input logic dbl, input logic [7:0] tx, input logic [7:0] mv);
    logic [7:0] mb, cap;
    logic pend;
    write_cfg(1'b0, pol, pha, rt, dbl);
    ss_n_i = 1'b1; sck_i = pol;
    @(negedge clk);
    tx_data_i = tx; tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 miso off while deselected", miso_oe_o, 1'b0);
    mb = mv; mosi_i = mb[7]; ss_n_i = 1'b0; pend = 1'b0; cap = '0;
    repeat (8) @(negedge clk);
    chk("R7 slave drives miso", {miso_oe_o, sck_oe_o}, 2'b10);
    for (int k = 0; k < 16; k++) begin
      logic lead, is_samp;
      lead = (k % 2) == 0;
      is_samp = pha ? !lead : lead;
      if (is_samp) begin
        cap = {cap[6:0], miso_o};
        pend = 1'b1;
      end
      sck_i = ~sck_i;
      if (!is_samp && pend) begin
        mb = {mb[6:0], 1'b0};
        mosi_i = mb[7];
        pend = 1'b0;
      end
      repeat (8) @(negedge clk);
    end
    chk("R7 slave flag", flag_o, 1'b1);
    chk("R7 slave received", rx_data_o, mv);
    chk("R4 slave MSB-first miso", cap, tx);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 miso off after deselect", miso_oe_o, 1'b0);
    clear_flag("R10 clear slave");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_i = 0; cfg_master_i = 0; cfg_cpol_i = 0; cfg_cpha_i = 0; cfg_rate_i = 0; cfg_dbl_i = 0;
    tx_wr_i = 0; tx_data_i = 0; flag_clr_i = 0;
    ss_n_i = 1; sck_i = 0; mosi_i = 0; miso_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 master bit", master_o, 1'b0);
    chk("R1 rx byte", rx_data_o, 8'h00);
    chk("R1 enables", {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b000);
    // R2 slave mode: a transmit write makes no clock
    tx_data_i = 8'h5A; tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 slave no clock", {sck_o, sck_oe_o, flag_o}, 3'b000);

    // master sweep: every polarity, phase, rate and speed (R3 R4 R5 R6)
    for (int c = 0; c < 32; c++) begin
      logic [7:0] tx, sv;
      tx = 8'(8'hA5 ^ (c * 37));
      sv = 8'(8'h3C + c * 53);
      run_master(c[0], c[1], c[3:2], c[4], tx, sv);
    end

    // slave sweep: rate bits must not matter (R7)
    for (int c = 0; c < 16; c++) begin
      logic [7:0] tx, mv;
      tx = 8'(8'hC3 + c * 29);
      mv = 8'(8'h81 ^ (c * 71));
      run_slave(c[0], c[1], c[3:2], c[0] ^ c[1], tx, mv);
    end

    // R8 cut-short byte followed by a full one
    write_cfg(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    sck_i = 1'b0; mosi_i = 1'b1; ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    sck_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 partial byte no flag", flag_o, 1'b0);
    run_slave(1'b0, 1'b0, 2'd1, 1'b0, 8'h96, 8'h4D);

    // R9 mode fault during a slow master transfer
    write_cfg(1'b1, 1'b1, 1'b0, 2'd3, 1'b0);
    chk("R9 master set", master_o, 1'b1);
    tx_data_i = 8'hF0; tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
    repeat (100) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 demoted", master_o, 1'b0);
    chk("R9 flag set", flag_o, 1'b1);
    chk("R9 clock released", sck_oe_o, 1'b0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 stays slave", {master_o, sck_oe_o}, 2'b00);
    clear_flag("R10 clear after fault");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule